// File: doc/BRIEF.md
# Page-mode DRAM read controller

This block pairs a read sequencer with a small behavioural DRAM array. By default the array is a grid of 4 rows by 4 columns of 8-bit supercells. The array sits behind one multiplexed address bus, which carries a row index while the row strobe is active and a column index while the column strobe is active. A client offers one read at a time as a (row, column) pair on a valid/ready port. The block returns the addressed supercell on a response port.

A row strobe copies a whole row into the array's internal row buffer. A column strobe takes one supercell out of that buffer. The sequencer remembers which row the buffer holds. A read that targets that row skips the row strobe and issues only a column strobe, which saves one cycle per read. A read to any other row opens its row first. The array contents are a fixed pattern set by two parameters, so any reader can compute the expected data.

Top module: `pagemode_rd_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1, `rsp_valid` is 0, and both strobes are 0. No row counts as open.
- R2: The first accepted read after reset issues a row strobe, with its row index on `mux_addr`, in the cycle right after acceptance. This is true even for a row that was open before the reset.
- R3: A read whose row differs from the open row produces a row-strobe cycle followed at once by a column-strobe cycle. During the column-strobe cycle, `mux_addr` carries the column index.
- R4: A read whose row equals the open row produces no row strobe. Its column strobe, with the column index on `mux_addr`, comes in the cycle right after acceptance.
- R5: `rsp_valid` is a one-cycle pulse in the cycle after each column strobe. It never occurs otherwise.
- R6: A request is accepted only on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the cycle after acceptance through the column-strobe cycle, and a `req_valid` driven during that time has no effect.
- R7: A read to a new row replaces the open row. A later read to the old row must strobe its row again.
- R8: The supercell at row r and column c holds (SEED xor ((r*COLS + c) * STEP)), truncated to DATA_W bits. With the defaults SEED = 0x3C and STEP = 0x29, this is the value returned on `rsp_data`.
- R9: The row strobe and the column strobe are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request offered |
| req_ready | output | 1 | Sequencer idle and able to accept a request |
| req_row | input | ROW_W (2) | Row index of the request |
| req_col | input | COL_W (2) | Column index of the request |
| rsp_valid | output | 1 | One-cycle pulse marking valid read data |
| rsp_data | output | DATA_W (8) | Supercell returned by the read |
| row_stb | output | 1 | Row strobe to the array |
| col_stb | output | 1 | Column strobe to the array |
| mux_addr | output | ADDR_W (2) | Shared address bus: row index with the row strobe, column index with the column strobe |

## Verification
The main function is driven with a run of reads inside one row, then jumps between rows, then a return to a row that was left. This separates a correct open-row tag from one that never hits, always hits, or keeps a stale row. A reset in the middle of the run, followed by a read to the row that was open before it, shows whether reset really clears the tag. One read is issued while `req_valid` is kept high through the busy cycles. It shows whether a busy sequencer takes a second request or produces an extra strobe. Every response is compared with the cell pattern at its own coordinates, and the cells are spread so that a wrong row or column index gives different data.

// File: rtl/pm_pkg.sv
package pm_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ROW  = 2'd1,
      ST_COL  = 2'd2
   } pm_state_t;

   // Content of the cell at linear position idx before truncation
   function automatic int unsigned pm_pattern(int unsigned idx,
                                              int unsigned seed,
                                              int unsigned step);
      return seed ^ (idx * step);
   endfunction

endpackage

// File: rtl/pm_cell_array.sv
module pm_cell_array #(
   parameter int unsigned ROWS   = 4,
   parameter int unsigned COLS   = 4,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 2,
   parameter int unsigned SEED   = 32'h3C,
   parameter int unsigned STEP   = 32'h29
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ras,
   input  logic              cas,
   input  logic [ADDR_W-1:0] addr,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data
);
   localparam int unsigned ROW_W = $clog2(ROWS);
   localparam int unsigned COL_W = $clog2(COLS);

   logic [DATA_W-1:0] cells   [ROWS][COLS];
   logic [DATA_W-1:0] row_buf [COLS];
   logic [ROW_W-1:0]  row_sel;
   logic [COL_W-1:0]  col_sel;

   // Fixed contents: one constant per supercell
   for (genvar r = 0; r < ROWS; r++) begin : g_row
      for (genvar c = 0; c < COLS; c++) begin : g_col
         assign cells[r][c] =
            DATA_W'(pm_pkg::pm_pattern(r * COLS + c, SEED, STEP));
      end
   end

   assign row_sel = addr[ROW_W-1:0];
   assign col_sel = addr[COL_W-1:0];

   // Row strobe: latch the whole selected row
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int c = 0; c < COLS; c++) row_buf[c] <= '0;
      end else if (ras) begin
         for (int c = 0; c < COLS; c++) row_buf[c] <= cells[row_sel][c];
      end
   end

   // Column strobe: pick one supercell out of the row buffer
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= cas;
         if (cas) rd_data <= row_buf[col_sel];
      end
   end

endmodule

// File: rtl/pm_row_tag.sv
module pm_row_tag #(
   parameter int unsigned ROW_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [ROW_W-1:0] load_row,
   input  logic [ROW_W-1:0] cmp_row,
   output logic             hit
);
   logic             open_valid;
   logic [ROW_W-1:0] open_row;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_valid <= 1'b0;
         open_row   <= '0;
      end else if (load) begin
         open_valid <= 1'b1;
         open_row   <= load_row;
      end
   end

   assign hit = open_valid && (open_row == cmp_row);

endmodule

// File: rtl/pm_rd_sequencer.sv
module pm_rd_sequencer #(
   parameter int unsigned ROW_W  = 2,
   parameter int unsigned COL_W  = 2,
   parameter int unsigned ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ROW_W-1:0]  req_row,
   input  logic [COL_W-1:0]  req_col,
   input  logic              row_hit,
   output logic              ras,
   output logic              cas,
   output logic [ADDR_W-1:0] addr,
   output logic              tag_load,
   output logic [ROW_W-1:0]  tag_row
);
   import pm_pkg::*;

   pm_state_t        state;
   logic [ROW_W-1:0] lat_row;
   logic [COL_W-1:0] lat_col;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         lat_row <= '0;
         lat_col <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (req_valid) begin
               lat_row <= req_row;
               lat_col <= req_col;
               state   <= row_hit ? ST_COL : ST_ROW;
            end
            ST_ROW:  state <= ST_COL;
            ST_COL:  state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (state == ST_IDLE);
   assign ras       = (state == ST_ROW);
   assign cas       = (state == ST_COL);

   always_comb begin
      if (ras)      addr = ADDR_W'(lat_row);
      else if (cas) addr = ADDR_W'(lat_col);
      else          addr = '0;
   end

   assign tag_load = ras;
   assign tag_row  = lat_row;

endmodule

// File: rtl/pagemode_rd_ctrl.sv
module pagemode_rd_ctrl #(
   parameter int unsigned ROWS   = 4,
   parameter int unsigned COLS   = 4,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned SEED   = 32'h3C,
   parameter int unsigned STEP   = 32'h29,
   localparam int unsigned ROW_W  = $clog2(ROWS),
   localparam int unsigned COL_W  = $clog2(COLS),
   localparam int unsigned ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ROW_W-1:0]  req_row,
   input  logic [COL_W-1:0]  req_col,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic              row_stb,
   output logic              col_stb,
   output logic [ADDR_W-1:0] mux_addr
);
   // Elaboration-time parameter checks
   if (ROWS < 2 || (ROWS & (ROWS - 1)) != 0) begin : g_bad_rows
      $error("ROWS must be a power of two, at least 2");
   end
   if (COLS < 2 || (COLS & (COLS - 1)) != 0) begin : g_bad_cols
      $error("COLS must be a power of two, at least 2");
   end
   if (DATA_W < 1 || DATA_W > 32) begin : g_bad_data
      $error("DATA_W must lie in 1..32");
   end

   logic             row_hit;
   logic             tag_load;
   logic [ROW_W-1:0] tag_row;

   pm_row_tag #(.ROW_W(ROW_W)) u_tag (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tag_load),
      .load_row (tag_row),
      .cmp_row  (req_row),
      .hit      (row_hit)
   );

   pm_rd_sequencer #(.ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_ready (req_ready),
      .req_row   (req_row),
      .req_col   (req_col),
      .row_hit   (row_hit),
      .ras       (row_stb),
      .cas       (col_stb),
      .addr      (mux_addr),
      .tag_load  (tag_load),
      .tag_row   (tag_row)
   );

   pm_cell_array #(
      .ROWS(ROWS), .COLS(COLS), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
      .SEED(SEED), .STEP(STEP)
   ) u_array (
      .clk      (clk),
      .rst_n    (rst_n),
      .ras      (row_stb),
      .cas      (col_stb),
      .addr     (mux_addr),
      .rd_valid (rsp_valid),
      .rd_data  (rsp_data)
   );

endmodule

// File: rtl/pm_rd_checker.sv
module pm_rd_checker #(
   parameter int unsigned ROW_W  = 2,
   parameter int unsigned ADDR_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [ROW_W-1:0]  req_row,
   input logic              row_stb,
   input logic              col_stb,
   input logic [ADDR_W-1:0] mux_addr,
   input logic              rsp_valid
);
   // Independent view of the open row, rebuilt from the strobe pins
   logic              seen_valid;
   logic [ADDR_W-1:0] seen_row;
   logic              accept;

   assign accept = req_valid && req_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen_valid <= 1'b0;
         seen_row   <= '0;
      end else if (row_stb) begin
         seen_valid <= 1'b1;
         seen_row   <= mux_addr;
      end
   end

   assert_reset_idle_R1: assert property (@(posedge clk)
      !rst_n |=> (req_ready && !rsp_valid && !row_stb && !col_stb));

   assert_first_row_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !seen_valid) |=> row_stb);

   assert_row_then_col_R3: assert property (@(posedge clk) disable iff (!rst_n)
      row_stb |=> col_stb);

   assert_hit_no_row_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && seen_valid && (ADDR_W'(req_row) == seen_row)) |=> (col_stb && !row_stb));

   assert_miss_reopens_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && seen_valid && (ADDR_W'(req_row) != seen_row)) |=> row_stb);

   assert_rsp_follows_col_R5: assert property (@(posedge clk) disable iff (!rst_n)
      col_stb |=> rsp_valid);

   assert_rsp_only_after_col_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(col_stb));

   assert_busy_after_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !req_ready);

   assert_busy_while_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (row_stb || col_stb) |-> !req_ready);

   assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(row_stb && col_stb));

endmodule

bind pagemode_rd_ctrl pm_rd_checker #(.ROW_W(ROW_W), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_row   (req_row),
   .row_stb   (row_stb),
   .col_stb   (col_stb),
   .mux_addr  (mux_addr),
   .rsp_valid (rsp_valid)
);

// File: tb/pagemode_rd_ctrl_tb.sv
module pagemode_rd_ctrl_tb;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       req_valid;
   logic       req_ready;
   logic [1:0] req_row;
   logic [1:0] req_col;
   logic       rsp_valid;
   logic [7:0] rsp_data;
   logic       row_stb;
   logic       col_stb;
   logic [1:0] mux_addr;

   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;

   // Bench model of the open row
   bit open_v   = 1'b0;
   int open_r   = 0;

   always #10 clk = ~clk;   // 50 MHz

   pagemode_rd_ctrl u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_ready (req_ready),
      .req_row   (req_row),
      .req_col   (req_col),
      .rsp_valid (rsp_valid),
      .rsp_data  (rsp_data),
      .row_stb   (row_stb),
      .col_stb   (col_stb),
      .mux_addr  (mux_addr)
   );

   function automatic logic [7:0] cell_val(int r, int c);
      int idx = r * 4 + c;
      return 8'((32'h3C ^ (idx * 32'h29)) & 32'hFF);
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      req_valid = 1'b0;
      repeat (2) @(negedge clk);
      check(req_ready && !rsp_valid && !row_stb && !col_stb, "R1 in reset",
            {req_ready, rsp_valid, row_stb, col_stb}, 4'b1000);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready && !rsp_valid && !row_stb && !col_stb, "R1 after reset",
            {req_ready, rsp_valid, row_stb, col_stb}, 4'b1000);
      open_v = 1'b0;
   endtask

   // One read; noise keeps req_valid high with other coordinates while busy
   task automatic read_chk(int r, int c, bit noise);
      bit miss = !open_v || (open_r != r);
      check(req_ready == 1'b1, "R6 ready before request", req_ready, 1);
      req_valid = 1'b1;
      req_row = 2'(r);
      req_col = 2'(c);
      @(negedge clk);                       // first cycle after acceptance
      if (noise) begin
         req_row = 2'(r + 1);
         req_col = 2'(c + 2);
      end else begin
         req_valid = 1'b0;
      end
      check(req_ready == 1'b0, "R6 busy after acceptance", req_ready, 0);
      if (miss) begin
         check(row_stb && !col_stb, open_v ? "R7 row strobe on new row" : "R2 first read strobes row",
               {row_stb, col_stb}, 2'b10);
         check(mux_addr == 2'(r), "R3 row index on bus", mux_addr, r);
         @(negedge clk);
         check(col_stb && !row_stb, "R3 column strobe follows row strobe",
               {row_stb, col_stb}, 2'b01);
      end else begin
         check(col_stb && !row_stb, "R4 open row skips row strobe",
               {row_stb, col_stb}, 2'b01);
      end
      check(mux_addr == 2'(c), "R3 R4 column index on bus", mux_addr, c);
      check(req_ready == 1'b0, "R6 busy in column strobe cycle", req_ready, 0);
      check(rsp_valid == 1'b0, "R5 no data during column strobe", rsp_valid, 0);
      req_valid = 1'b0;
      @(negedge clk);
      check(rsp_valid == 1'b1, "R5 data valid after column strobe", rsp_valid, 1);
      check(rsp_data == cell_val(r, c), "R8 returned supercell", rsp_data, cell_val(r, c));
      @(negedge clk);
      check(!rsp_valid && !row_stb && !col_stb, "R5 R6 single pulse, nothing pending",
            {rsp_valid, row_stb, col_stb}, 0);
      if (noise) begin
         @(negedge clk);
         check(!rsp_valid && !row_stb && !col_stb, "R6 busy request left no trace",
               {rsp_valid, row_stb, col_stb}, 0);
      end
      open_v = 1'b1;
      open_r = r;
   endtask

   task automatic test_page_run();
      read_chk(1, 2, 1'b0);   // R2 first read
      read_chk(1, 0, 1'b0);   // R4 hits
      read_chk(1, 3, 1'b0);
      read_chk(1, 1, 1'b0);
   endtask

   task automatic test_row_jumps();
      read_chk(3, 3, 1'b0);   // R7 miss
      read_chk(0, 0, 1'b0);
      read_chk(0, 3, 1'b0);
      read_chk(1, 2, 1'b0);   // R7 return to a left row
      read_chk(2, 1, 1'b0);
   endtask

   task automatic test_reset_clears_row();
      read_chk(2, 2, 1'b0);
      do_reset();
      read_chk(2, 0, 1'b0);   // R2 must strobe the row again
   endtask

   task automatic test_busy_noise();
      read_chk(3, 1, 1'b1);   // R6 miss with request held
      read_chk(3, 2, 1'b1);   // R6 hit with request held
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      rst_n = 1'b0;
      req_valid = 1'b0;
      req_row = '0;
      req_col = '0;
      do_reset();
      test_page_run();
      test_row_jumps();
      test_reset_clears_row();
      test_busy_noise();
      finish_run();
   end

   initial begin
      repeat (5000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

endmodule